// File: doc/BRIEF.md
# Serial Configuration Register Loader

This block takes configuration bytes from a write-only serial port and places them in three 8-bit registers: control, frequency and pulse width. The port has an active-low select, a serial clock that idles low and a data line. Data is sampled on the rising edge of the serial clock, most significant bit first. All three serial inputs are sampled by a faster system clock. Each one passes through a two-flop synchronizer, and serial clock edges are detected in the system clock domain.

While select is low the block counts the bits it receives. When select goes high it decides from that count which registers to write. The byte received last always goes to pulse width. A 16-bit write also sets frequency from its first byte. Only a full 24-bit write, sent as control, frequency, pulse width, also sets control. A transfer of any other length writes nothing. Each accepted write raises a one-cycle strobe together with a mask that shows which registers changed. A sticky flag goes high once the first full 24-bit write has been stored.

Top module: `serld_top`

## Requirements
- R1: While reset is high and in the first cycle after it, all three registers read 0, `init_done` is 0 and `load_stb` is 0.
- R2: A transfer of exactly 8 bits, sent MSB first and sampled on serial clock rising edges, writes that byte to `pw_q`. `freq_q` and `ctrl_q` keep their values. The mask is 3'b001.
- R3: A transfer of exactly 16 bits writes the first byte to `freq_q` and the second byte to `pw_q`. `ctrl_q` keeps its value. The mask is 3'b011.
- R4: A transfer of exactly 24 bits writes the bytes, in order, to `ctrl_q`, `freq_q` and `pw_q`. The mask is 3'b111.
- R5: A transfer whose bit count is not 8, 16 or 24 writes no register and raises no strobe. This includes a select window with no clocks and counts above 24.
- R6: Registers change only after select is released. Each accepted write gives exactly one single-cycle `load_stb` pulse, with `load_mask` (bit 0 pulse width, bit 1 frequency, bit 2 control) naming the registers written. No register changes in any other cycle.
- R7: `init_done` stays 0 until the first 24-bit write has been stored. It rises in the same cycle as that write's strobe and then stays 1 until reset.
- R8: Serial clock edges while select is high are neither shifted nor counted. The bit count restarts at every new select window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, samples the serial pins |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Serial select, active low |
| sck | input | 1 | Serial clock, idles low |
| sdi | input | 1 | Serial data, MSB first |
| ctrl_q | output | 8 | Control register |
| freq_q | output | 8 | Frequency register |
| pw_q | output | 8 | Pulse width register |
| init_done | output | 1 | Sticky flag: a full 24-bit write has been stored |
| load_stb | output | 1 | One-cycle pulse when registers are written |
| load_mask | output | 3 | Registers written with this strobe |

## Verification
The assertions check four things on every cycle. A register changes only in a strobe cycle whose mask bit covers it. The strobe lasts one cycle. The mask is always one of the three legal patterns. The initialization flag is sticky and rises only with a full write. Only the bench scenarios can show that the data is right: MSB-first byte order, the mapping from transfer length to registers, rejection of 0-, 7-, 12- and 25-bit transfers, and stray serial clocks while deselected being ignored.

// File: rtl/serld_pkg.sv
package serld_pkg;

    localparam int BYTE_W     = 8;
    localparam int NUM_REGS   = 3;
    localparam int TOTAL_BITS = BYTE_W * NUM_REGS;
    localparam int CNT_W      = $clog2(TOTAL_BITS + 2);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef logic [BYTE_W-1:0]     byte_t;
    typedef logic [NUM_REGS-1:0]   reg_mask_t;
    typedef logic [CNT_W-1:0]      bit_cnt_t;
    typedef logic [TOTAL_BITS-1:0] frame_t;

    // synchronized serial pins
    typedef struct packed {
        logic cs_n;
        logic sck;
        logic sdi;
    } serial_pins_t;

    // events derived in the system clock domain
    typedef struct packed {
        logic sck_rise;
        logic cs_fall;
        logic cs_rise;
        logic selected;
        logic sdi;
    } serial_events_t;

    // register index 0 = pulse width, 1 = frequency, 2 = control
    function automatic reg_mask_t count_to_mask(input bit_cnt_t n);
        reg_mask_t m;
        m = '0;
        for (int k = 1; k <= NUM_REGS; k++) begin
            if (n == bit_cnt_t'(k * BYTE_W)) begin
                for (int i = 0; i < k; i++) m[i] = 1'b1;
            end
        end
        return m;
    endfunction

    function automatic bit_cnt_t count_step(input bit_cnt_t n);
        return (n == CNT_MAX) ? n : n + bit_cnt_t'(1);
    endfunction

endpackage

// File: rtl/serld_sync.sv
module serld_sync #(
    parameter int             WIDTH   = 3,
    parameter int             STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= RST_VAL;
        end else begin
            stage_q[0] <= d;
            for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
        end
    end

    assign q = stage_q[STAGES-1];

endmodule

// File: rtl/serld_events.sv
module serld_events
    import serld_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  serial_pins_t   pins,
    output serial_events_t ev
);

    serial_pins_t prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q.cs_n <= 1'b1;
            prev_q.sck  <= 1'b0;
            prev_q.sdi  <= 1'b0;
        end else begin
            prev_q <= pins;
        end
    end

    always_comb begin
        ev.sck_rise = pins.sck & ~prev_q.sck;
        ev.cs_fall  = ~pins.cs_n & prev_q.cs_n;
        ev.cs_rise  = pins.cs_n & ~prev_q.cs_n;
        ev.selected = ~pins.cs_n;
        ev.sdi      = pins.sdi;
    end

endmodule

// File: rtl/serld_shifter.sv
module serld_shifter
    import serld_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  serial_events_t ev,
    output frame_t         frame,
    output bit_cnt_t       bit_cnt
);

    frame_t   frame_q;
    bit_cnt_t cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            frame_q <= '0;
            cnt_q   <= '0;
        end else if (ev.cs_fall) begin
            frame_q <= '0;
            cnt_q   <= '0;
        end else if (ev.selected && ev.sck_rise) begin
            frame_q <= {frame_q[TOTAL_BITS-2:0], ev.sdi};
            cnt_q   <= count_step(cnt_q);
        end
    end

    assign frame   = frame_q;
    assign bit_cnt = cnt_q;

endmodule

// File: rtl/serld_bank.sv
module serld_bank
    import serld_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      release_evt,
    input  frame_t    frame,
    input  bit_cnt_t  bit_cnt,
    output byte_t     regs [NUM_REGS],
    output logic      load_stb,
    output reg_mask_t load_mask,
    output logic      init_done
);

    reg_mask_t sel_mask;
    logic      do_load;
    logic      stb_q;
    reg_mask_t mask_q;
    logic      init_q;

    assign sel_mask = count_to_mask(bit_cnt);
    assign do_load  = release_evt && (sel_mask != '0);

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        byte_t r_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                r_q <= '0;
            end else if (do_load && sel_mask[g]) begin
                r_q <= frame[g*BYTE_W +: BYTE_W];
            end
        end
        assign regs[g] = r_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stb_q  <= 1'b0;
            mask_q <= '0;
            init_q <= 1'b0;
        end else begin
            stb_q  <= do_load;
            mask_q <= do_load ? sel_mask : '0;
            if (do_load && (&sel_mask)) init_q <= 1'b1;
        end
    end

    assign load_stb  = stb_q;
    assign load_mask = mask_q;
    assign init_done = init_q;

endmodule

// File: rtl/serld_top.sv
module serld_top
    import serld_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cs_n,
    input  logic                sck,
    input  logic                sdi,
    output logic [BYTE_W-1:0]   ctrl_q,
    output logic [BYTE_W-1:0]   freq_q,
    output logic [BYTE_W-1:0]   pw_q,
    output logic                init_done,
    output logic                load_stb,
    output logic [NUM_REGS-1:0] load_mask
);

    localparam int IDX_PW   = 0;
    localparam int IDX_FREQ = 1;
    localparam int IDX_CTRL = 2;

    serial_pins_t   raw_pins;
    serial_pins_t   sync_pins;
    serial_events_t ev;
    frame_t         frame;
    bit_cnt_t       bit_cnt;
    byte_t          regs [NUM_REGS];

    assign raw_pins = '{cs_n: cs_n, sck: sck, sdi: sdi};

    serld_sync #(
        .WIDTH   ($bits(serial_pins_t)),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b100)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_pins),
        .q   (sync_pins)
    );

    serld_events u_events (
        .clk  (clk),
        .rst  (rst),
        .pins (sync_pins),
        .ev   (ev)
    );

    serld_shifter u_shift (
        .clk     (clk),
        .rst     (rst),
        .ev      (ev),
        .frame   (frame),
        .bit_cnt (bit_cnt)
    );

    serld_bank u_bank (
        .clk         (clk),
        .rst         (rst),
        .release_evt (ev.cs_rise),
        .frame       (frame),
        .bit_cnt     (bit_cnt),
        .regs        (regs),
        .load_stb    (load_stb),
        .load_mask   (load_mask),
        .init_done   (init_done)
    );

    assign pw_q   = regs[IDX_PW];
    assign freq_q = regs[IDX_FREQ];
    assign ctrl_q = regs[IDX_CTRL];

endmodule

// File: rtl/serld_checker.sv
module serld_checker (
    input logic       clk,
    input logic       rst,
    input logic [7:0] ctrl_q,
    input logic [7:0] freq_q,
    input logic [7:0] pw_q,
    input logic       init_done,
    input logic       load_stb,
    input logic [2:0] load_mask
);

    AST_PW_ONLY_ON_LOAD: assert property (@(posedge clk) disable iff (rst)
        !$stable(pw_q) |-> (load_stb && load_mask[0])); // R6

    AST_FREQ_ONLY_ON_LOAD: assert property (@(posedge clk) disable iff (rst)
        !$stable(freq_q) |-> (load_stb && load_mask[1])); // R3

    AST_CTRL_ONLY_ON_LOAD: assert property (@(posedge clk) disable iff (rst)
        !$stable(ctrl_q) |-> (load_stb && load_mask[2])); // R4

    AST_STB_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        load_stb |=> !load_stb); // R6

    AST_MASK_LEGAL: assert property (@(posedge clk) disable iff (rst)
        load_stb |-> (load_mask == 3'b001 || load_mask == 3'b011 || load_mask == 3'b111)); // R5

    AST_MASK_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !load_stb |-> (load_mask == 3'b000)); // R6

    AST_INIT_STICKY: assert property (@(posedge clk) disable iff (rst)
        init_done |=> init_done); // R7

    AST_INIT_RISE_FULL: assert property (@(posedge clk) disable iff (rst)
        $rose(init_done) |-> (load_stb && load_mask == 3'b111)); // R7

endmodule

bind serld_top serld_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .ctrl_q    (ctrl_q),
    .freq_q    (freq_q),
    .pw_q      (pw_q),
    .init_done (init_done),
    .load_stb  (load_stb),
    .load_mask (load_mask)
);

// File: tb/serld_top_test.sv
`timescale 1ns/1ps
module serld_top_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs_n = 1'b1;
    logic       sck = 1'b0;
    logic       sdi = 1'b0;
    logic [7:0] ctrl_q, freq_q, pw_q;
    logic       init_done, load_stb;
    logic [2:0] load_mask;

    always #10 clk = ~clk; // 50 MHz

    serld_top uut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .sdi(sdi),
        .ctrl_q(ctrl_q), .freq_q(freq_q), .pw_q(pw_q),
        .init_done(init_done), .load_stb(load_stb), .load_mask(load_mask)
    );

    typedef struct {
        logic [2:0] mask;
        logic [7:0] c, f, p;
        string      tag;
    } exp_item_t;

    exp_item_t  sb_q[$];
    int         checks = 0;
    int         errors = 0;
    logic [7:0] e_ctrl = 8'h00, e_freq = 8'h00, e_pw = 8'h00;
    logic       e_init = 1'b0;

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic check_regs(input string tag);
        chk(tag, "ctrl_q", ctrl_q, e_ctrl);
        chk(tag, "freq_q", freq_q, e_freq);
        chk(tag, "pw_q", pw_q, e_pw);
        chk(tag, "init_done", init_done, e_init);
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // driver: sends nbits of bits, MSB first, then releases select
    task automatic xfer(input int nbits, input logic [31:0] bits, input string tag);
        exp_item_t it;
        cs_n = 1'b0;
        wait_cyc(4);
        for (int i = nbits - 1; i >= 0; i--) begin
            sdi = bits[i];
            wait_cyc(4);
            sck = 1'b1;
            wait_cyc(4);
            sck = 1'b0;
        end
        wait_cyc(6);
        check_regs("R6"); // nothing latched while still selected
        if (nbits == 8 || nbits == 16 || nbits == 24) begin
            e_pw = bits[7:0];
            it.mask = 3'b001;
            if (nbits >= 16) begin e_freq = bits[15:8]; it.mask = 3'b011; end
            if (nbits == 24) begin e_ctrl = bits[23:16]; it.mask = 3'b111; end
            it.c = e_ctrl; it.f = e_freq; it.p = e_pw; it.tag = tag;
            sb_q.push_back(it);
        end
        cs_n = 1'b1;
        wait_cyc(8);
        if (nbits == 24) e_init = 1'b1;
        check_regs(tag);
    endtask

    task automatic stray_sck(input int n);
        sdi = 1'b1;
        for (int i = 0; i < n; i++) begin
            wait_cyc(4); sck = 1'b1; wait_cyc(4); sck = 1'b0;
        end
        wait_cyc(6);
    endtask

    // monitor: pops expected items as strobes appear
    always @(negedge clk) begin
        if (!rst && load_stb) begin
            if (sb_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL R5 unexpected strobe: actual mask=%0h expected none", load_mask);
            end else begin
                exp_item_t it;
                it = sb_q.pop_front();
                chk(it.tag, "load_mask", load_mask, it.mask);
                chk(it.tag, "strobe ctrl", ctrl_q, it.c);
                chk(it.tag, "strobe freq", freq_q, it.f);
                chk(it.tag, "strobe pw", pw_q, it.p);
                if (it.mask == 3'b111) chk("R7", "init at strobe", init_done, 1);
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        wait_cyc(3);
        chk("R1", "stb in reset", load_stb, 0);
        check_regs("R1");
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "stb after reset", load_stb, 0);
        chk("R1", "mask after reset", load_mask, 0);
        check_regs("R1");
        wait_cyc(4);

        xfer(8,  32'h0000_00A5, "R2");       // pulse width only, before init
        chk("R7", "init after 8-bit", init_done, 0);
        xfer(16, 32'h0000_3C81, "R3");       // frequency then pulse width
        chk("R7", "init after 16-bit", init_done, 0);
        xfer(0,  32'h0,         "R5");       // empty window
        xfer(7,  32'h0000_007F, "R5");
        xfer(12, 32'h0000_0FFF, "R5");
        xfer(25, 32'h01FF_FFFF, "R5");
        chk("R7", "init after bad", init_done, 0);
        xfer(24, 32'h00C3_5A96, "R4");       // full write
        chk("R7", "init after 24-bit", init_done, 1);
        xfer(8,  32'h0000_0001, "R2");
        xfer(16, 32'h0000_8000, "R3");
        stray_sck(5);
        check_regs("R8");
        xfer(8,  32'h0000_00E7, "R8");       // count restarts, stray edges ignored
        xfer(24, 32'h0012_3456, "R4");
        xfer(40, 32'hFFFF_FFFF, "R5");       // saturating count, rejected
        chk("R7", "init sticky", init_done, 1);
        wait_cyc(10);
        chk("R6", "scoreboard drained", sb_q.size(), 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule